// File: doc/BRIEF.md
# SDRAM Command Scheduler with Read-Return Bus Shadow

This block turns simple memory requests into a command stream for a single-data-rate SDRAM bus. Each request names a rank, bank, row and column, and carries write data when it is a write. The scheduler keeps the open row of every bank in every rank. A request that hits the open row goes straight to its column command. A request to an idle bank first opens the row. A request that finds a different row open first closes that row, then opens the new one. Activate-to-column and precharge-to-activate spacing are parameters.

Reads return data on the shared data pins a programmed number of cycles after the read command. Writes must drive their data in the same cycle as the write command. To keep the two apart, the scheduler keeps a short shift register that marks the future cycles in which read data will occupy the pins. It holds back any write whose command cycle is already marked. Returned read data is captured in its arrival cycle and presented one cycle later with a valid strobe. Commands are pipelined: new requests are accepted and issued while earlier reads are still in flight.

Top module: `sdram_cmd_sched`

## Requirements
- R1: After reset, `cmd_code` is 0 (idle), every `cmd_cs_n` bit is 1, `dq_oe` and `rd_valid` are 0, and `req_ready` is 1. Command codes are: 0 idle, 1 activate, 2 read, 3 write, 4 precharge.
- R2: A request accepted in cycle a whose row is open in its rank and bank issues only the column command (read 2 or write 3), in cycle a+1. `cmd_bank` carries the bank and `cmd_addr` carries the column, zero-extended.
- R3: A request to a bank with no open row issues activate (code 1) in cycle a+1, with the row on `cmd_addr`. Its column command follows exactly T_RCD cycles after the activate, and no command is issued in between.
- R4: A request to a bank that has a different row open issues precharge (code 4) in cycle a+1. It issues activate T_RP cycles after the precharge, then the column command T_RCD cycles after the activate. Activate is only issued to a closed bank and precharge only to an open one.
- R5: For a write command, `dq_out` carries the request's write data and `dq_oe` is 1 in the same cycle as the command. `dq_oe` is 0 in every other cycle.
- R6: For a read issued in cycle k, the block captures `dq_in` in cycle k+CL. It presents that value on `rd_data` with `rd_valid` high in cycle k+CL+1.
- R7: CL is taken from `cas_lat`, which may be set to any value from 1 to MAX_CL while no read is in flight. Both 2 and 3 are honoured.
- R8: A write command is never issued in a cycle in which read data returns on the data pins. A write held back this way is issued in the first free cycle after that one.
- R9: Every non-idle command drives exactly one `cmd_cs_n` bit low, the bit of the request's rank. All bits are high when the command is idle.
- R10: Open rows are tracked separately for every rank and bank. Opening a row in one rank or bank does not make a request to another rank or bank a hit.
- R11: `req_ready` is low while a request's activate, precharge or stalled column phase is pending. Row hits that are not stalled are accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | CL_W | Programmed read latency in cycles (1..MAX_CL) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_rank | input | RANK_W | Target rank |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| cmd_cs_n | output | NUM_RANKS | Per-rank active-low select |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ROW_W | Row for activate, column for read/write |
| dq_out | output | DATA_W | Write data driven onto the data pins |
| dq_oe | output | 1 | Data pin drive enable |
| dq_in | input | DATA_W | Data arriving from the memory |
| rd_valid | output | 1 | Returned read data valid |
| rd_data | output | DATA_W | Returned read data |

## Verification
The bench builds the block with two ranks, four banks, a 10-bit row, a 6-bit column, MAX_CL of 3, T_RCD of 3 and T_RP of 2. Because the activate gap differs from the precharge gap, a swapped timer shows up as a command in the wrong cycle. The run uses latency 3 and then latency 2, so the write hold-back is reached at two distinct return offsets. The top row and top column values are exercised, and so are rank-1 and bank-1 requests that would falsely hit if open rows were shared across ranks or banks.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_COL  = 2'd2
    } sched_st_e;

endpackage

// File: rtl/sched_row_table.sv
module sched_row_table #(
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RANK_W-1:0] look_rank,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [RANK_W-1:0] upd_rank,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    localparam int IDX_W   = RANK_W + BANK_W;
    localparam int NUM_ENT = 1 << IDX_W;

    logic [IDX_W-1:0]   upd_idx;
    logic [IDX_W-1:0]   look_idx;
    logic [NUM_ENT-1:0] open_vec;
    logic [ROW_W-1:0]   row_arr [NUM_ENT];

    assign upd_idx  = {upd_rank, upd_bank};
    assign look_idx = {look_rank, look_bank};

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic             open_d, open_q;
        logic [ROW_W-1:0] row_d, row_q;
        logic             sel;

        assign sel = (upd_idx == IDX_W'(e));

        always_comb begin
            open_d = open_q;
            row_d  = row_q;
            if (set_en && sel) begin
                open_d = 1'b1;
                row_d  = upd_row;
            end else if (clr_en && sel) begin
                open_d = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else begin
                open_q <= open_d;
                row_q  <= row_d;
            end
        end

        assign open_vec[e] = open_q;
        assign row_arr[e]  = row_q;
    end

    assign look_open = open_vec[look_idx];
    assign look_row  = row_arr[look_idx];

    // R4: activation only of a closed bank, precharge only of an open one
    assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !open_vec[upd_idx]);
    assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> open_vec[upd_idx]);

endmodule

// File: rtl/sched_bus_shadow.sv
module sched_bus_shadow #(
    parameter int MAX_CL = 3,
    parameter int DATA_W = 16,
    parameter int CL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              bus_next,
    output logic              bus_now,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOTS = MAX_CL + 1;

    typedef struct packed {
        logic [SLOTS-1:0]  busy;
        logic              vld;
        logic [DATA_W-1:0] data;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.busy = sh_q.busy >> 1;
        if (rd_issue && (int'(cas_lat) <= MAX_CL)) begin
            sh_d.busy[cas_lat] = 1'b1;
        end
        sh_d.vld = sh_q.busy[0];
        if (sh_q.busy[0]) begin
            sh_d.data = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bus_now  = sh_q.busy[0];
    assign bus_next = sh_q.busy[1];
    assign rd_valid = sh_q.vld;
    assign rd_data  = sh_q.data;

    // R7: a read is only issued with a latency the shadow can hold
    assert_cl_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> (cas_lat != '0) && (int'(cas_lat) <= MAX_CL));

endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched #(
    parameter int NUM_RANKS = 2,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int MAX_CL    = 3,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CL_W     = $clog2(MAX_CL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CL_W-1:0]      cas_lat,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [RANK_W-1:0]    req_rank,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [NUM_RANKS-1:0] cmd_cs_n,
    output logic [2:0]           cmd_code,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [ROW_W-1:0]     cmd_addr,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe,
    input  logic [DATA_W-1:0]    dq_in,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data
);
    import sched_pkg::*;

    localparam int GAP_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMR_W   = $clog2(GAP_MAX + 1);

    typedef struct packed {
        sched_st_e            st;
        logic [TMR_W-1:0]     tmr;
        logic                 wr;
        logic [RANK_W-1:0]    rank;
        logic [BANK_W-1:0]    bank;
        logic [ROW_W-1:0]     row;
        logic [COL_W-1:0]     col;
        logic [DATA_W-1:0]    wdata;
        sdram_cmd_e           cmd;
        logic [NUM_RANKS-1:0] cs_n;
        logic [BANK_W-1:0]    cbank;
        logic [ROW_W-1:0]     caddr;
        logic                 oe;
        logic [DATA_W-1:0]    dout;
    } ctl_t;

    ctl_t s_d, s_q;

    logic                 idle;
    logic                 cur_wr;
    logic [RANK_W-1:0]    cur_rank;
    logic [BANK_W-1:0]    cur_bank;
    logic [ROW_W-1:0]     cur_row;
    logic [COL_W-1:0]     cur_col;
    logic [DATA_W-1:0]    cur_wdata;
    logic [NUM_RANKS-1:0] cs_sel;
    logic                 look_open;
    logic [ROW_W-1:0]     look_row;
    logic                 bus_next;
    logic                 bus_now;

    assign idle      = (s_q.st == ST_IDLE);
    assign cur_wr    = idle ? req_write : s_q.wr;
    assign cur_rank  = idle ? req_rank  : s_q.rank;
    assign cur_bank  = idle ? req_bank  : s_q.bank;
    assign cur_row   = idle ? req_row   : s_q.row;
    assign cur_col   = idle ? req_col   : s_q.col;
    assign cur_wdata = idle ? req_wdata : s_q.wdata;

    always_comb begin
        cs_sel           = '1;
        cs_sel[cur_rank] = 1'b0;
    end

    sched_row_table #(
        .RANK_W (RANK_W),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_rank (cur_rank),
        .look_bank (cur_bank),
        .look_open (look_open),
        .look_row  (look_row),
        .set_en    (s_d.cmd == CMD_ACT),
        .clr_en    (s_d.cmd == CMD_PRE),
        .upd_rank  (cur_rank),
        .upd_bank  (cur_bank),
        .upd_row   (cur_row)
    );

    sched_bus_shadow #(
        .MAX_CL (MAX_CL),
        .DATA_W (DATA_W),
        .CL_W   (CL_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas_lat  (cas_lat),
        .rd_issue (s_d.cmd == CMD_RD),
        .dq_in    (dq_in),
        .bus_next (bus_next),
        .bus_now  (bus_now),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_comb begin
        s_d       = s_q;
        s_d.cmd   = CMD_NOP;
        s_d.cs_n  = '1;
        s_d.cbank = '0;
        s_d.caddr = '0;
        s_d.oe    = 1'b0;
        s_d.dout  = '0;
        s_d.tmr   = (s_q.tmr != '0) ? s_q.tmr - 1'b1 : '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.wr    = req_write;
                    s_d.rank  = req_rank;
                    s_d.bank  = req_bank;
                    s_d.row   = req_row;
                    s_d.col   = req_col;
                    s_d.wdata = req_wdata;
                    if (look_open && (look_row == req_row)) begin
                        if (!req_write || !bus_next) begin
                            s_d.cmd   = req_write ? CMD_WR : CMD_RD;
                            s_d.cs_n  = cs_sel;
                            s_d.cbank = cur_bank;
                            s_d.caddr = ROW_W'(cur_col);
                            s_d.oe    = req_write;
                            s_d.dout  = req_write ? cur_wdata : '0;
                        end else begin
                            s_d.st = ST_COL;
                        end
                    end else if (look_open) begin
                        s_d.cmd   = CMD_PRE;
                        s_d.cs_n  = cs_sel;
                        s_d.cbank = cur_bank;
                        s_d.st    = ST_ACT;
                        s_d.tmr   = TMR_W'(T_RP - 1);
                    end else begin
                        s_d.cmd   = CMD_ACT;
                        s_d.cs_n  = cs_sel;
                        s_d.cbank = cur_bank;
                        s_d.caddr = cur_row;
                        s_d.st    = ST_COL;
                        s_d.tmr   = TMR_W'(T_RCD - 1);
                    end
                end
            end
            ST_ACT: begin
                if (s_q.tmr == '0) begin
                    s_d.cmd   = CMD_ACT;
                    s_d.cs_n  = cs_sel;
                    s_d.cbank = cur_bank;
                    s_d.caddr = cur_row;
                    s_d.st    = ST_COL;
                    s_d.tmr   = TMR_W'(T_RCD - 1);
                end
            end
            ST_COL: begin
                if ((s_q.tmr == '0) && (!cur_wr || !bus_next)) begin
                    s_d.cmd   = cur_wr ? CMD_WR : CMD_RD;
                    s_d.cs_n  = cs_sel;
                    s_d.cbank = cur_bank;
                    s_d.caddr = ROW_W'(cur_col);
                    s_d.oe    = cur_wr;
                    s_d.dout  = cur_wr ? cur_wdata : '0;
                    s_d.st    = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = idle;
    assign cmd_code  = s_q.cmd;
    assign cmd_cs_n  = s_q.cs_n;
    assign cmd_bank  = s_q.cbank;
    assign cmd_addr  = s_q.caddr;
    assign dq_out    = s_q.dout;
    assign dq_oe     = s_q.oe;

    // Gap counters observed at the command pins, for spacing checks
    localparam int GC_W = $clog2(GAP_MAX + 1) + 1;
    logic [GC_W-1:0] gap_act_q, gap_pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_act_q <= GC_W'(GAP_MAX);
            gap_pre_q <= GC_W'(GAP_MAX);
        end else begin
            if (cmd_code == CMD_ACT)               gap_act_q <= GC_W'(1);
            else if (gap_act_q < GC_W'(GAP_MAX))   gap_act_q <= gap_act_q + 1'b1;
            if (cmd_code == CMD_PRE)               gap_pre_q <= GC_W'(1);
            else if (gap_pre_q < GC_W'(GAP_MAX))   gap_pre_q <= gap_pre_q + 1'b1;
        end
    end

    assert_act_to_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code == CMD_RD) || (cmd_code == CMD_WR)) |-> (int'(gap_act_q) >= T_RCD));
    assert_pre_to_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_ACT) |-> (int'(gap_pre_q) >= T_RP));
    assert_no_bus_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !bus_now);
    assert_one_rank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cmd_cs_n) <= 1);
    assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_NOP) == (&cmd_cs_n));
    assert_busy_after_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_ACT) |-> !req_ready);

endmodule

// File: tb/sdram_cmd_sched_bench.sv
module sdram_cmd_sched_bench;

    localparam int NR = 2, NB = 4, RW = 10, CW = 6, DW = 16;
    localparam int MCL = 3, TRCD = 3, TRP = 2;

    typedef struct packed {
        logic        wr;
        logic [0:0]  rk;
        logic [1:0]  bk;
        logic [9:0]  row;
        logic [5:0]  col;
        logic [15:0] wd;
        logic [1:0]  kind;   // 0 hit, 1 closed bank, 2 row conflict
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 1'b0, 2'd0, 10'd5,    6'd3,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 2'd0, 10'd5,    6'd4,  16'h0000, 2'd0},
        '{1'b1, 1'b0, 2'd0, 10'd5,    6'd7,  16'hBEEF, 2'd0},
        '{1'b1, 1'b0, 2'd0, 10'd9,    6'd1,  16'h1234, 2'd2},
        '{1'b0, 1'b1, 2'd0, 10'd9,    6'd2,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 2'd1, 10'd9,    6'd2,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 2'd0, 10'd9,    6'd5,  16'h0000, 2'd0},
        '{1'b1, 1'b1, 2'd0, 10'd3,    6'd6,  16'h0F0F, 2'd2},
        '{1'b0, 1'b1, 2'd3, 10'd1023, 6'd63, 16'h0000, 2'd1},
        '{1'b1, 1'b1, 2'd3, 10'd1023, 6'd0,  16'hFFFF, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cas_lat = 2'd3;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [0:0]    req_rank = '0;
    logic [1:0]    req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NR-1:0] cmd_cs_n;
    logic [2:0]    cmd_code;
    logic [1:0]    cmd_bank;
    logic [RW-1:0] cmd_addr;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic [DW-1:0] dq_in = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    sdram_cmd_sched #(
        .NUM_RANKS(NR), .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
        .MAX_CL(MCL), .T_RCD(TRCD), .T_RP(TRP)
    ) u_sdram_cmd_sched (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata),
        .cmd_cs_n(cmd_cs_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    int lg_cyc [256], lg_code [256], lg_cs [256], lg_bank [256], lg_addr [256];
    int lg_oe [256], lg_dq [256];
    int n_lg = 0;
    int rv_cyc [256], rv_dat [256];
    int n_rv = 0;
    logic          ret_v [64];
    logic [DW-1:0] ret_d [64];

    function automatic logic [DW-1:0] pat(int rk, int bk, int col);
        return 16'h5A00 ^ 16'(rk * 256 + bk * 64 + col);
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            ret_v[i] = 1'b0;
            ret_d[i] = '0;
        end
    end

    // memory model and monitor, sampled mid-cycle
    always @(negedge clk) begin
        dq_in = ret_v[cyc % 64] ? ret_d[cyc % 64] : '0;
        ret_v[cyc % 64] = 1'b0;
        if (cmd_code == 3'd2) begin
            ret_v[(cyc + int'(cas_lat)) % 64] = 1'b1;
            ret_d[(cyc + int'(cas_lat)) % 64] =
                pat((cmd_cs_n == 2'b01) ? 1 : 0, int'(cmd_bank), int'(cmd_addr));
        end
        if (cmd_code != 3'd0 && n_lg < 256) begin
            lg_cyc[n_lg]  = cyc;
            lg_code[n_lg] = int'(cmd_code);
            lg_cs[n_lg]   = int'(cmd_cs_n);
            lg_bank[n_lg] = int'(cmd_bank);
            lg_addr[n_lg] = int'(cmd_addr);
            lg_oe[n_lg]   = int'(dq_oe);
            lg_dq[n_lg]   = int'(dq_out);
            n_lg++;
        end
        if (rd_valid && n_rv < 256) begin
            rv_cyc[n_rv] = cyc;
            rv_dat[n_rv] = int'(rd_data);
            n_rv++;
        end
    end

    task automatic chk_eq(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int find_cmd(int c);
        for (int i = 0; i < n_lg; i++) if (lg_cyc[i] == c) return i;
        return -1;
    endfunction

    function automatic int find_rv(int c);
        for (int i = 0; i < n_rv; i++) if (rv_cyc[i] == c) return i;
        return -1;
    endfunction

    task automatic do_req(bit wr, int rk, int bk, int row, int col, int wd, output int acc);
        req_valid = 1'b1;
        req_write = wr;
        req_rank  = 1'(rk);
        req_bank  = 2'(bk);
        req_row   = RW'(row);
        req_col   = CW'(col);
        req_wdata = DW'(wd);
        while (!req_ready) @(negedge clk);
        acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_col(string tag, int c, bit wr, int rk, int bk, int col, int wd);
        int i;
        int j;
        i = find_cmd(c);
        chk_eq(tag, "column command present", int'(i >= 0), 1);
        if (i >= 0) begin
            chk_eq(tag, "column code", lg_code[i], wr ? 3 : 2);
            chk_eq("R9", "column cs_n", lg_cs[i], (~(1 << rk)) & 3);
            chk_eq(tag, "column bank", lg_bank[i], bk);
            chk_eq(tag, "column addr", lg_addr[i], col);
            chk_eq("R5", "data drive with command", lg_oe[i], int'(wr));
            if (wr) chk_eq("R5", "write data", lg_dq[i], wd);
        end
        if (!wr) begin
            j = find_rv(c + int'(cas_lat) + 1);
            chk_eq("R6", "read return present", int'(j >= 0), 1);
            if (j >= 0) chk_eq("R6", "read return data", rv_dat[j], int'(pat(rk, bk, col)));
        end
    endtask

    task automatic chk_act(string tag, int c, int rk, int bk, int row);
        int i;
        i = find_cmd(c);
        chk_eq(tag, "activate present", int'(i >= 0), 1);
        if (i >= 0) begin
            chk_eq(tag, "activate code", lg_code[i], 1);
            chk_eq(tag, "activate addr", lg_addr[i], row);
            chk_eq(tag, "activate bank", lg_bank[i], bk);
            chk_eq("R9", "activate cs_n", lg_cs[i], (~(1 << rk)) & 3);
        end
    endtask

    task automatic run_vec(vec_t v);
        int acc;
        int i;
        do_req(v.wr, int'(v.rk), int'(v.bk), int'(v.row), int'(v.col), int'(v.wd), acc);
        repeat (14) @(negedge clk);
        case (v.kind)
            2'd0: begin
                chk_col("R2", acc + 1, v.wr, int'(v.rk), int'(v.bk), int'(v.col), int'(v.wd));
            end
            2'd1: begin
                chk_act("R3/R10", acc + 1, int'(v.rk), int'(v.bk), int'(v.row));
                chk_eq("R3", "idle between activate and column", find_cmd(acc + 2), -1);
                chk_col("R3", acc + 1 + TRCD, v.wr, int'(v.rk), int'(v.bk), int'(v.col), int'(v.wd));
            end
            default: begin
                i = find_cmd(acc + 1);
                chk_eq("R4", "precharge present", int'(i >= 0), 1);
                if (i >= 0) chk_eq("R4", "precharge code", lg_code[i], 4);
                chk_act("R4", acc + 1 + TRP, int'(v.rk), int'(v.bk), int'(v.row));
                chk_col("R4", acc + 1 + TRP + TRCD, v.wr, int'(v.rk), int'(v.bk),
                        int'(v.col), int'(v.wd));
            end
        endcase
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int a1, a2, a3, a4, a5;
        int i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_eq("R1", "cmd_code", int'(cmd_code), 0);
        chk_eq("R1", "cmd_cs_n", int'(cmd_cs_n), 3);
        chk_eq("R1", "dq_oe", int'(dq_oe), 0);
        chk_eq("R1", "rd_valid", int'(rd_valid), 0);
        chk_eq("R1", "req_ready", int'(req_ready), 1);

        for (int k = 0; k < 10; k++) begin
            run_vec(VEC[k]);
        end

        // R8 and R11 at latency 3: read hit then a stream of write hits
        do_req(1'b0, 0, 0, 9, 1, 0, a1);
        do_req(1'b1, 0, 0, 9, 2, 16'hA1A1, a2);
        do_req(1'b1, 0, 0, 9, 3, 16'hA2A2, a3);
        do_req(1'b1, 0, 0, 9, 4, 16'hA3A3, a4);
        do_req(1'b0, 0, 0, 9, 5, 0, a5);
        repeat (12) @(negedge clk);
        chk_eq("R11", "back-to-back hit accept", a2 - a1, 1);
        chk_eq("R11", "third hit accept", a3 - a1, 2);
        chk_col("R2", a1 + 1, 1'b0, 0, 0, 1, 0);
        chk_col("R2", a1 + 2, 1'b1, 0, 0, 2, 16'hA1A1);
        chk_col("R2", a1 + 3, 1'b1, 0, 0, 3, 16'hA2A2);
        chk_eq("R8", "stalled write not issued on return cycle", find_cmd(a1 + 4), -1);
        chk_col("R8", a1 + 5, 1'b1, 0, 0, 4, 16'hA3A3);
        chk_eq("R11", "ready low during stall", a5 - a1, 5);
        chk_col("R11", a1 + 6, 1'b0, 0, 0, 5, 0);

        // R7 and R8 at latency 2
        cas_lat = 2'd2;
        @(negedge clk);
        do_req(1'b0, 1, 3, 1023, 9, 0, a1);
        do_req(1'b1, 1, 3, 1023, 10, 16'hC3C3, a2);
        do_req(1'b1, 1, 3, 1023, 11, 16'h3C3C, a3);
        repeat (12) @(negedge clk);
        chk_col("R7", a1 + 1, 1'b0, 1, 3, 9, 0);
        chk_col("R7", a1 + 2, 1'b1, 1, 3, 10, 16'hC3C3);
        chk_eq("R8", "latency-2 return cycle free of writes", find_cmd(a1 + 3), -1);
        chk_col("R8", a1 + 4, 1'b1, 1, 3, 11, 16'h3C3C);
        i = find_rv(a1 + 4);
        chk_eq("R7", "latency-2 return strobe", int'(i >= 0), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule